// File: doc/BRIEF.md
# PHY Management Bus Master

This block is the host side of a two-wire station management bus to an Ethernet PHY. Software programs a small bank of 32-bit registers with a management clock divider, a preamble option, a PHY and register number and, for writes, a 16-bit data word. A write to the command register then launches one clause-22 management frame. The block generates the management clock (MDC) from the system clock and shifts the frame out on the data line. For a read it releases the line and captures the PHY's reply.

A continuous scan command repeats reads of the addressed PHY register back to back. After each scan read a link-fail flag is refreshed from bit 2 of the returned word, inverted. A status register reports busy, link fail and whether scan data is valid yet. The bidirectional data pad is modelled as three signals: an output value, an output enable and an input.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset every register reads zero, `mdc` is low and `mdio_oe` is low.
- R2: The clock divider is mode bits [7:0] with bit 0 ignored, and any value below 2 is treated as 2. While a frame runs, one MDC period lasts that many system clocks. MDC is held low while idle.
- R3: Command bit 2 requests a write, bit 1 a read and bit 0 a scan. When several are set, scan wins over read and read wins over write. Writing zero starts nothing.
- R4: A frame is 32 ones (left out when mode bit 8 is set), then start 01, then opcode 01 for write or 10 for read, then the PHY address from address-register bits [4:0], then the register address from bits [12:8]. A write continues with turnaround 10 and the 16 transmit-data bits, MSB first. The data line changes only when MDC falls.
- R5: For a read, `mdio_oe` drops from the first turnaround bit to the end of the frame. `mdio_i` is sampled on the 16 rising MDC edges of the data field. The value appears in receive-data bits [15:0] when busy clears, and that register changes at no other time.
- R6: Status bit 1 (busy) reads 1 from the cycle after an accepted command until the frame completes.
- R7: A command written while busy is ignored: no extra frame follows and the read/write command bits read back unchanged. The only exception is clearing bit 0, which stops a running scan.
- R8: Scan runs back-to-back reads. Status bit 2 (invalid) is set when scan starts and clears after the first scan read. Status bit 0 (link fail) becomes the inverse of bit 2 of each result. Writing a command with bit 0 clear ends scan after the current frame.
- R9: Word index 0 is mode, 1 command, 2 address, 3 transmit data, 4 receive data, 5 status. Receive data and status are read-only. Unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The hardest situation to reach is a scan whose PHY answer changes while scan keeps running. The link flag must follow the newest result, and the stop request must take effect only at a frame boundary. The bench holds a PHY model that answers every read from a variable. It first lets the first scan read complete to observe invalid clearing, then flips the answer mid-scan, waits several frames and finally stops scan by command write. A second hard case is a command landing during a busy frame. The bench issues it a few cycles after launching a write and then watches the bus for a spurious second frame.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 32;
    localparam int TA_POS     = 14;
    localparam int DATA_POS   = 16;
    localparam int DATA_W     = 16;
    localparam int HALF_W     = 7;

    typedef enum logic [2:0] {
        RA_MODE = 3'd0,
        RA_CMD  = 3'd1,
        RA_ADDR = 3'd2,
        RA_TXD  = 3'd3,
        RA_RXD  = 3'd4,
        RA_STAT = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic              rd;
        logic              nopre;
        logic [4:0]        phy;
        logic [4:0]        regn;
        logic [DATA_W-1:0] wdata;
    } frame_req_t;

    function automatic logic [HALF_W-1:0] eff_half(input logic [7:0] div);
        return (div[7:1] == 7'd0) ? HALF_W'(1) : div[7:1];
    endfunction

    function automatic logic [FRAME_BITS-1:0] frame_word(input frame_req_t r);
        return {2'b01, (r.rd ? 2'b10 : 2'b01), r.phy, r.regn,
                (r.rd ? 2'b11 : 2'b10), (r.rd ? 16'hFFFF : r.wdata)};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_mgmt_pkg::*;
#(
    parameter int HW = HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [HW-1:0] half,
    output logic          mdc,
    output logic          rise,
    output logic          fall
);
    logic [HW-1:0] cnt;
    logic          term;

    assign term = (cnt == half - HW'(1));
    assign rise = en && term && !mdc;
    assign fall = en && term && mdc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (term) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + HW'(1);
        end
    end

    AST_CNT_BELOW_HALF: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt < half)); // R2

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  frame_req_t        req,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int TOTAL = PRE_BITS + FRAME_BITS;
    localparam int IW    = $clog2(TOTAL);
    localparam logic [IW-1:0] IDX_FRAME = IW'(PRE_BITS);
    localparam logic [IW-1:0] IDX_TA    = IW'(PRE_BITS + TA_POS);
    localparam logic [IW-1:0] IDX_DATA  = IW'(PRE_BITS + DATA_POS);
    localparam logic [IW-1:0] IDX_LAST  = IW'(TOTAL - 1);

    logic [IW-1:0]         idx;
    frame_req_t            req_q;
    logic [DATA_W-1:0]     rx_sh;
    logic [FRAME_BITS-1:0] fw;
    logic [IW-1:0]         pos;
    logic                  bit_val;
    logic                  released;

    assign fw       = frame_word(req_q);
    assign pos      = idx - IDX_FRAME;
    assign bit_val  = (idx < IDX_FRAME) ? 1'b1 : fw[5'd31 - pos[4:0]];
    assign released = req_q.rd && (idx >= IDX_TA);
    assign mdio_o   = active ? bit_val : 1'b0;
    assign mdio_oe  = active && !released;
    assign rdata    = rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            done   <= 1'b0;
            idx    <= '0;
            req_q  <= '0;
            rx_sh  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                req_q  <= req;
                idx    <= req.nopre ? IDX_FRAME : '0;
            end else if (active) begin
                if (rise && req_q.rd && idx >= IDX_DATA)
                    rx_sh <= {rx_sh[DATA_W-2:0], mdio_i};
                if (fall) begin
                    if (idx == IDX_LAST) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        idx <= idx + IW'(1);
                    end
                end
            end
        end
    end

    AST_IDX_FROM_START: assert property (@(posedge clk) disable iff (rst)
        (active && req_q.nopre) |-> (idx >= IDX_FRAME)); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [8:0]        mode_q;
    logic [2:0]        cmd_q;
    logic [4:0]        phy_q;
    logic [4:0]        regad_q;
    logic [DATA_W-1:0] txd_q;
    logic [DATA_W-1:0] rxd_q;
    logic [HALF_W-1:0] half_q;
    logic              busy_q, start_q, link_fail_q, invalid_q;
    logic              scan_frm_q, rd_frm_q;

    frame_req_t        req;
    logic              rise, fall, eng_active, eng_done;
    logic [DATA_W-1:0] eng_rdata;
    logic              cmd_wr, clr_scan, cont;
    logic              unused_wdata;

    assign unused_wdata = ^{reg_wdata[31:17], reg_wdata[7:5]};
    assign cmd_wr   = reg_wr && (reg_addr == RA_CMD);
    assign clr_scan = cmd_wr && busy_q && !reg_wdata[0];
    assign cont     = cmd_q[0] && !clr_scan;

    always_comb begin
        req.rd    = cmd_q[0] | cmd_q[1];
        req.nopre = mode_q[8];
        req.phy   = phy_q;
        req.regn  = regad_q;
        req.wdata = txd_q;
    end

    mdio_mdc_gen #(.HW(HALF_W)) u_mdc (
        .clk (clk), .rst (rst), .en (eng_active), .half (half_q),
        .mdc (mdc), .rise (rise), .fall (fall)
    );

    mdio_frame_eng u_eng (
        .clk (clk), .rst (rst), .start (start_q), .req (req),
        .rise (rise), .fall (fall), .mdio_i (mdio_i),
        .active (eng_active), .done (eng_done), .rdata (eng_rdata),
        .mdio_o (mdio_o), .mdio_oe (mdio_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= '0;
            cmd_q       <= '0;
            phy_q       <= '0;
            regad_q     <= '0;
            txd_q       <= '0;
            rxd_q       <= '0;
            half_q      <= HALF_W'(1);
            busy_q      <= 1'b0;
            start_q     <= 1'b0;
            link_fail_q <= 1'b0;
            invalid_q   <= 1'b0;
            scan_frm_q  <= 1'b0;
            rd_frm_q    <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (reg_wr) begin
                case (reg_idx_e'(reg_addr))
                    RA_MODE: mode_q <= reg_wdata[8:0];
                    RA_ADDR: begin
                        phy_q   <= reg_wdata[4:0];
                        regad_q <= reg_wdata[12:8];
                    end
                    RA_TXD:  txd_q <= reg_wdata[15:0];
                    RA_CMD: begin
                        if (!busy_q) begin
                            cmd_q <= reg_wdata[2:0];
                            if (|reg_wdata[2:0]) begin
                                busy_q  <= 1'b1;
                                start_q <= 1'b1;
                                half_q  <= eff_half(mode_q[7:0]);
                            end
                            if (reg_wdata[0])
                                invalid_q <= 1'b1;
                        end else if (!reg_wdata[0]) begin
                            cmd_q[0] <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            if (start_q) begin
                scan_frm_q <= cmd_q[0];
                rd_frm_q   <= req.rd;
            end
            if (eng_done) begin
                if (rd_frm_q)
                    rxd_q <= eng_rdata;
                if (scan_frm_q) begin
                    link_fail_q <= ~eng_rdata[2];
                    invalid_q   <= 1'b0;
                end
                if (cont) start_q <= 1'b1;
                else      busy_q  <= 1'b0;
            end
        end
    end

    always_comb begin
        case (reg_idx_e'(reg_addr))
            RA_MODE: reg_rdata = {23'd0, mode_q};
            RA_CMD:  reg_rdata = {29'd0, cmd_q};
            RA_ADDR: reg_rdata = {19'd0, regad_q, 3'd0, phy_q};
            RA_TXD:  reg_rdata = {16'd0, txd_q};
            RA_RXD:  reg_rdata = {16'd0, rxd_q};
            RA_STAT: reg_rdata = {29'd0, invalid_q, busy_q, link_fail_q};
            default: reg_rdata = 32'd0;
        endcase
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (!mdc && !mdio_oe)); // R2

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !eng_done) |=> busy_q); // R6

    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (eng_active && $past(eng_active) && !$stable(mdio_o)) |-> $fell(mdc)); // R4

    AST_RXD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !eng_done |=> $stable(rxd_q)); // R5

    AST_INVALID_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (eng_done && scan_frm_q) |=> !invalid_q); // R8

    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy_q && !eng_done) |=> (busy_q && $stable(cmd_q[2:1]))); // R7

endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i;

    int checks = 0;
    int errors = 0;

    logic [63:0] cap;
    int          capcnt;
    int          cyc, last_rise, period, k;
    logic        prev_mdc;
    logic [15:0] phy_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt_master dut_i (
        .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .mdc (mdc),
        .mdio_o (mdio_o), .mdio_oe (mdio_oe), .mdio_i (mdio_i)
    );

    // PHY model: acts between system clock edges
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            prev_mdc <= 1'b0;
            mdio_i   <= 1'b1;
            k        <= 0;
        end else begin
            prev_mdc <= mdc;
            if (mdc && !prev_mdc) begin
                period    <= cyc - last_rise;
                last_rise <= cyc;
                if (mdio_oe) begin
                    cap    <= {cap[62:0], mdio_o};
                    capcnt <= capcnt + 1;
                end
            end
            if (mdio_oe) begin
                k      <= 0;
                mdio_i <= 1'b1;
            end else if (!mdc && prev_mdc) begin
                k <= k + 1;
                if (k + 1 == 2)                    mdio_i <= 1'b0;
                else if (k + 1 >= 3 && k + 1 <= 18) mdio_i <= phy_data[18 - (k + 1)];
                else                               mdio_i <= 1'b1;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_cap();
        @(negedge clk);
        capcnt = 0; cap = '0;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] s;
        bit ok = 0;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd5, s);
            if (!s[1]) begin ok = 1; break; end
        end
        chk({req, " frame completes"}, ok, 1'b1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 register zero after reset", v, 0);
        end
        chk("R1 mdc low", mdc, 1'b0);
        chk("R1 oe low", mdio_oe, 1'b0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk("R9 mode readback", v, 32'h1FF);
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); chk("R9 address readback", v, 32'h1F1F);
        wr(3'd3, 32'hFFFF_1234); rd(3'd3, v); chk("R9 txdata readback", v, 32'h1234);
        wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, v); chk("R9 rxdata read-only", v, 0);
        wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, v); chk("R9 status read-only", v, 0);
        wr(3'd0, 0);
    endtask

    task automatic t_write();
        logic [31:0] v;
        clear_cap();
        wr(3'd0, 32'd4);
        wr(3'd2, 32'h0000_0B12);
        wr(3'd3, 32'h0000_A5C3);
        wr(3'd1, 32'd4);
        rd(3'd5, v); chk("R6 busy after command", v[1], 1'b1);
        wait_idle("R6");
        chk("R4 write bit count", capcnt, 64);
        chk("R4 write frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h12, 5'h0B, 2'b10, 16'hA5C3});
        chk("R2 period div 4", period, 4);
        rd(3'd1, v); chk("R3 command readback", v, 4);
    endtask

    task automatic t_read_nopre();
        logic [31:0] v;
        clear_cap();
        phy_data = 16'h3C5A;
        wr(3'd0, 32'h0000_0103);
        wr(3'd2, 32'h0000_1F01);
        wr(3'd1, 32'd2);
        wait_idle("R5");
        chk("R5 driven bits without preamble", capcnt, 14);
        chk("R5 read header", cap[13:0], {2'b01, 2'b10, 5'h01, 5'h1F});
        rd(3'd4, v); chk("R5 read data", v, 32'h3C5A);
        chk("R2 odd divider 3 gives 2", period, 2);
    endtask

    task automatic t_read_div0();
        logic [31:0] v;
        clear_cap();
        phy_data = 16'h8001;
        wr(3'd0, 32'd0);
        wr(3'd1, 32'd2);
        wait_idle("R2");
        chk("R2 divider 0 gives 2", period, 2);
        chk("R4 read driven bits with preamble", capcnt, 46);
        chk("R4 read header with preamble", cap[45:0], {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h01, 5'h1F});
        rd(3'd4, v); chk("R5 read data 2", v, 32'h8001);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        clear_cap();
        wr(3'd0, 32'd2);
        wr(3'd1, 32'd4);
        wr(3'd1, 32'd2);
        rd(3'd1, v); chk("R7 command unchanged while busy", v, 4);
        wait_idle("R7");
        repeat (60) @(negedge clk);
        rd(3'd5, v); chk("R7 no second frame busy", v[1], 1'b0);
        chk("R7 only one frame on bus", capcnt, 64);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        clear_cap();
        phy_data = 16'h00F0;
        wr(3'd1, 32'd6);
        wait_idle("R3");
        chk("R3 read wins over write", capcnt, 46);
        chk("R3 read opcode", cap[13:10], 4'b0110);
        clear_cap();
        wr(3'd1, 32'd0);
        repeat (5) @(negedge clk);
        rd(3'd5, v); chk("R3 zero command starts nothing", v[1], 1'b0);
        chk("R3 no bits after zero command", capcnt, 0);
    endtask

    task automatic t_scan();
        logic [31:0] v;
        bit ok = 0;
        phy_data = 16'h0000;
        wr(3'd0, 32'd2);
        wr(3'd2, 32'h0000_0101);
        wr(3'd1, 32'd1);
        rd(3'd5, v); chk("R8 scan start busy and invalid", v[2:0], 3'b110);
        for (int i = 0; i < 5000; i++) begin
            rd(3'd5, v);
            if (!v[2]) begin ok = 1; break; end
        end
        chk("R8 invalid clears", ok, 1'b1);
        chk("R8 link fail set, still busy", v[2:0], 3'b011);
        phy_data = 16'h0004;
        repeat (400) @(negedge clk);
        rd(3'd5, v); chk("R8 link fail follows new result", v[2:0], 3'b010);
        wr(3'd1, 32'd0);
        wait_idle("R8");
        rd(3'd4, v); chk("R8 last scan result", v, 32'h0004);
        rd(3'd5, v); chk("R8 status after stop", v, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        phy_data = 16'h0; cap = '0; capcnt = 0; cyc = 0; last_rise = 0; period = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_write();
        t_read_nopre();
        t_read_div0();
        t_busy_ignore();
        t_priority();
        t_scan();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule